// File: doc/BRIEF.md
# Card Slot Fault and Event Status Latch

This block gathers hardware fault and event indications for a two-slot smart card interface. It holds them in a read-only 8-bit status word and drives an active-low interrupt line to the host. Each slot contributes a protection fault, made from supply-output and reset-output fault pulses, and a presence contact level. The block also watches an auxiliary interrupt pin, an overheat flag and a supervisor alarm pulse. The supervisor alarm is raised at power-on and on a supply drop-out.

Presence and auxiliary inputs are latched on any level change. Fault inputs are latched while they are high. A single read strobe stands for a host read of the status word. That read clears exactly the flags the host saw, and any event arriving in the same cycle is kept. The supervisor flag obeys its own rule: it cannot be cleared while the alarm pulse is still high.

Whenever an emergency condition is latched, the block pulses a start-clear output so that the activation-start control bit elsewhere in the interface is reset by hardware.

Top module: `card_fault_latch`

## Requirements
- R1: The status word `status_o` has this layout: bit 7 is always 0, bit 6 is the slot-2 protection flag, bit 5 is the slot-1 protection flag, bit 4 is the supervisor flag, bit 3 is the slot-2 presence-change flag, bit 2 is the slot-1 presence-change flag, bit 1 is the auxiliary-change flag and bit 0 is the overheat flag.
- R2: A slot's protection flag becomes set when either that slot's supply fault input or its reset fault input is high at a clock edge. Index 0 of each per-slot input vector is slot 1.
- R3: A presence-change flag becomes set on a rising or a falling change of its presence input, detected against the value from the previous cycle. The first sample after reset never counts as a change.
- R4: When `aux_mask_i` is 0, any level change of `aux_irq_i` sets the auxiliary flag. When `aux_mask_i` is 1, a change does not set the flag, and a flag already set does not pull the interrupt low.
- R5: `irq_n_o` is 0 in three cases: while any protection, presence or overheat flag is set; while the auxiliary flag is set and unmasked; or while `alarm_i` is high. Otherwise it is 1.
- R6: A cycle with `rd_stb_i` high clears, at that clock edge, every flag shown in `status_o` during that cycle. The supervisor flag is the exception covered by R8.
- R7: An event that is captured in the same cycle as `rd_stb_i` leaves its flag set after the read.
- R8: The supervisor flag is set at every clock edge where `alarm_i` is high. A read while `alarm_i` is high leaves it set. It clears only on a read while `alarm_i` is low.
- R9: `start_clr_o` is high for the cycle right after an edge at which a protection, presence, overheat or supervisor event was captured. Auxiliary events never raise it.
- R10: While reset is asserted and afterwards, with no events, every flag is 0, `start_clr_o` is 0 and `irq_n_o` is 1 (with `alarm_i` low).
- R11: A flag appears in `status_o` one clock edge after its input event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_fault_i | input | 2 | Supply-output fault pulse per slot |
| rst_fault_i | input | 2 | Reset-output fault pulse per slot |
| pres_i | input | 2 | Card presence level per slot |
| aux_irq_i | input | 1 | Auxiliary interrupt pin level |
| aux_mask_i | input | 1 | Disables the auxiliary flag and its interrupt |
| overheat_i | input | 1 | Overheat indication |
| alarm_i | input | 1 | Supervisor alarm pulse |
| rd_stb_i | input | 1 | One-cycle status read strobe |
| status_o | output | 8 | Status word |
| irq_n_o | output | 1 | Active-low interrupt |
| start_clr_o | output | 1 | Request to clear the activation-start bit |

## Verification
The assertions assume that every input is already synchronous to `clk`. They also assume that a read strobe lasts exactly one cycle per host read. The bench keeps to this by changing inputs only on falling clock edges and by raising `rd_stb_i` for one cycle at a time. The bench holds `alarm_i` low through reset, so the reset state can be observed with the interrupt released. It presets `pres_i` to a nonzero value before reset, which lets the first post-reset sample show that it causes no false change.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int NUM_SLOTS = 2;
    localparam int STAT_W    = 8;
    // layout of the event flag bank (supervisor lives elsewhere)
    localparam int EV_OVH    = 0;
    localparam int EV_AUX    = 1;
    localparam int EV_PRES   = 2;
    localparam int EV_PROT   = EV_PRES + NUM_SLOTS;
    localparam int EV_W      = EV_PROT + NUM_SLOTS;
    // level-change watch vector: presence pins then auxiliary pin
    localparam int CHG_W     = NUM_SLOTS + 1;
endpackage

// File: rtl/cfl_edge_det.sv
module cfl_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] chg_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         primed;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = lvl_i;
        st_d.primed = 1'b1;
        chg_o       = st_q.primed ? (lvl_i ^ st_q.prev) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: after the first sample, the change output tracks input movement
    assert_change_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && (lvl_i != st_q.prev)) |-> (chg_o != '0));
endmodule

// File: rtl/cfl_flag_bank.sv
module cfl_flag_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i) st_d.flag = set_i;            // drop what was shown, keep fresh events
        else      st_d.flag = st_q.flag | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flag_o & $past(set_i)) == $past(set_i)));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((flag_o & ~$past(set_i)) == '0));
endmodule

// File: rtl/cfl_supervisor.sv
module cfl_supervisor (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_i,
    input  logic rd_i,
    output logic sup_o
);
    typedef struct packed {
        logic sup;
    } sup_state_t;

    sup_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (alarm_i)   st_d.sup = 1'b1;
        else if (rd_i) st_d.sup = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sup_o = st_q.sup;

    assert_alarm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_i |=> sup_o);

    assert_read_after_alarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !alarm_i) |=> !sup_o);
endmodule

// File: rtl/card_fault_latch.sv
module card_fault_latch
    import cfl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] vcc_fault_i,
    input  logic [NUM_SLOTS-1:0] rst_fault_i,
    input  logic [NUM_SLOTS-1:0] pres_i,
    input  logic                 aux_irq_i,
    input  logic                 aux_mask_i,
    input  logic                 overheat_i,
    input  logic                 alarm_i,
    input  logic                 rd_stb_i,
    output logic [STAT_W-1:0]    status_o,
    output logic                 irq_n_o,
    output logic                 start_clr_o
);
    typedef struct packed {
        logic start_clr;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CHG_W-1:0] chg;
    logic [EV_W-1:0]  ev_set;
    logic [EV_W-1:0]  ev_flag;
    logic             sup_flag;
    logic             emerg_set;
    logic             irq_active;

    cfl_edge_det #(.W(CHG_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({aux_irq_i, pres_i}),
        .chg_o (chg)
    );

    always_comb begin
        ev_set                        = '0;
        ev_set[EV_OVH]                = overheat_i;
        ev_set[EV_AUX]                = chg[NUM_SLOTS] & ~aux_mask_i;
        ev_set[EV_PRES +: NUM_SLOTS]  = chg[NUM_SLOTS-1:0];
        ev_set[EV_PROT +: NUM_SLOTS]  = vcc_fault_i | rst_fault_i;
    end

    cfl_flag_bank #(.W(EV_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .rd_i   (rd_stb_i),
        .flag_o (ev_flag)
    );

    cfl_supervisor u_sup (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm_i (alarm_i),
        .rd_i    (rd_stb_i),
        .sup_o   (sup_flag)
    );

    always_comb begin
        st_d           = st_q;
        emerg_set      = (|ev_set[EV_PROT +: NUM_SLOTS]) | (|ev_set[EV_PRES +: NUM_SLOTS])
                       | ev_set[EV_OVH] | alarm_i;
        st_d.start_clr = emerg_set;
        irq_active     = (|ev_flag[EV_PROT +: NUM_SLOTS]) | (|ev_flag[EV_PRES +: NUM_SLOTS])
                       | ev_flag[EV_OVH] | (ev_flag[EV_AUX] & ~aux_mask_i) | alarm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o    = {1'b0, ev_flag[EV_PROT +: NUM_SLOTS], sup_flag,
                          ev_flag[EV_PRES +: NUM_SLOTS], ev_flag[EV_AUX], ev_flag[EV_OVH]};
    assign irq_n_o     = ~irq_active;
    assign start_clr_o = st_q.start_clr;

    // emergency bits of the status word: protection, supervisor, presence, overheat
    logic [5:0] emerg_vec;
    assign emerg_vec = {status_o[6:2], status_o[0]};

    assert_emerg_start_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((emerg_vec & ~$past(emerg_vec)) != '0) |-> start_clr_o);

    assert_aux_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_mask_i && !status_o[1]) |=> !status_o[1]);

    assert_spare_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[7]);
endmodule

// File: tb/tb_card_fault_latch.sv
module tb_card_fault_latch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] vcc_fault = '0;
    logic [1:0] rst_fault = '0;
    logic [1:0] pres = '0;
    logic       aux = 1'b0;
    logic       aux_mask = 1'b0;
    logic       ovh = 1'b0;
    logic       alarm = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] status;
    logic       irq_n;
    logic       start_clr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_fault_latch dut (
        .clk(clk), .rst_n(rst_n), .vcc_fault_i(vcc_fault), .rst_fault_i(rst_fault),
        .pres_i(pres), .aux_irq_i(aux), .aux_mask_i(aux_mask), .overheat_i(ovh),
        .alarm_i(alarm), .rd_stb_i(rd), .status_o(status), .irq_n_o(irq_n),
        .start_clr_o(start_clr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1'b1;
        step();
        rd = 1'b0;
    endtask

    task automatic t_reset();
        pres = 2'b01;
        rst_n = 1'b0;
        repeat (3) step();
        chk("R10 status in reset", status, 8'h00);
        chk("R10 irq_n in reset", {7'b0, irq_n}, 8'h01);
        chk("R10 start_clr in reset", {7'b0, start_clr}, 8'h00);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R3 no change on first sample", status, 8'h00);
        chk("R10 irq_n after reset", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_protect();
        vcc_fault = 2'b01;
        step();
        vcc_fault = 2'b00;
        chk("R2 slot1 supply fault", status, 8'h20);
        chk("R9 start_clr on protection", {7'b0, start_clr}, 8'h01);
        chk("R5 irq low on protection", {7'b0, irq_n}, 8'h00);
        step();
        chk("R9 start_clr one cycle", {7'b0, start_clr}, 8'h00);
        chk("R2 flag held", status, 8'h20);
        do_read();
        chk("R6 read clears protection", status, 8'h00);
        chk("R5 irq released", {7'b0, irq_n}, 8'h01);
        rst_fault = 2'b10;
        step();
        rst_fault = 2'b00;
        chk("R2 slot2 reset fault", status, 8'h40);
        do_read();
        chk("R6 clear slot2", status, 8'h00);
    endtask

    task automatic t_presence();
        pres = 2'b11;
        step();
        chk("R3 slot2 rising change", status, 8'h08);
        chk("R9 start_clr on presence", {7'b0, start_clr}, 8'h01);
        do_read();
        chk("R6 clear presence", status, 8'h00);
        pres = 2'b01;
        step();
        chk("R3 slot2 falling change", status, 8'h08);
        pres = 2'b00;
        step();
        chk("R3 slot1 falling change", status, 8'h0C);
        do_read();
        chk("R6 clear both presence", status, 8'h00);
    endtask

    task automatic t_aux();
        aux = 1'b1;
        step();
        chk("R4 aux change latched", status, 8'h02);
        chk("R5 irq low on aux", {7'b0, irq_n}, 8'h00);
        chk("R9 no start_clr on aux", {7'b0, start_clr}, 8'h00);
        aux_mask = 1'b1;
        step();
        chk("R4 masked aux flag kept", status, 8'h02);
        chk("R4 masked aux no irq", {7'b0, irq_n}, 8'h01);
        aux_mask = 1'b0;
        do_read();
        chk("R6 clear aux", status, 8'h00);
        aux_mask = 1'b1;
        aux = 1'b0;
        step();
        step();
        chk("R4 masked change ignored", status, 8'h00);
        chk("R4 masked irq high", {7'b0, irq_n}, 8'h01);
        aux_mask = 1'b0;
        step();
        chk("R4 unmask no late flag", status, 8'h00);
    endtask

    task automatic t_overheat_coincide();
        pres = 2'b01;
        step();
        chk("R11 presence next edge", status, 8'h04);
        ovh = 1'b1;
        rd = 1'b1;
        step();
        rd = 1'b0;
        ovh = 1'b0;
        chk("R7 event kept through read", status, 8'h01);
        chk("R9 start_clr on overheat", {7'b0, start_clr}, 8'h01);
        do_read();
        chk("R6 clear overheat", status, 8'h00);
        pres = 2'b00;
        step();
        do_read();
        chk("R6 clean state", status, 8'h00);
    endtask

    task automatic t_supervisor();
        alarm = 1'b1;
        step();
        chk("R8 alarm sets supervisor", status, 8'h10);
        chk("R5 irq low during alarm", {7'b0, irq_n}, 8'h00);
        chk("R9 start_clr on alarm", {7'b0, start_clr}, 8'h01);
        do_read();
        chk("R8 read in alarm keeps flag", status, 8'h10);
        alarm = 1'b0;
        step();
        chk("R5 irq high after alarm", {7'b0, irq_n}, 8'h01);
        chk("R8 flag held after alarm", status, 8'h10);
        do_read();
        chk("R8 read after alarm clears", status, 8'h00);
    endtask

    initial begin
        t_reset();
        t_protect();
        t_presence();
        t_aux();
        t_overheat_coincide();
        t_supervisor();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule